// File: doc/BRIEF.md
# Programmable Watchdog Timer

The block is a bus-mapped watchdog. A slow tick is derived from the system clock by two stages. The first is an 8-bit programmable prescaler that divides by P+1. The second is a selectable fixed divider of 16, 32, 64 or 128. Each tick lowers a 16-bit down-counter by one. When the counter runs out, it reloads from a separate reload register. The expiry can then raise a one-cycle interrupt, a long reset pulse, both, or neither, as set by two independent enable bits in the control register.

Software keeps the system alive by writing the count register before the counter runs out. Software can also use the timer to force a system reset. It stops the timer, loads a short count, then starts it with only the reset path enabled. All three registers are 32 bits wide. Bits that are not implemented read as zero.

Top module: `wdog_timer`

## Requirements
- R1: After a synchronous reset, control reads 0x0000_8039, which is prescaler 0x80, divider ÷128, counting on, reset path on and interrupt path off. Reload and count read 0x0000_8000, and both outputs are low.
- R2: The register map is: control at byte address 0x0, reload at 0x4 (bits [15:0]), count at 0x8 (bits [15:0]). In control, bits [15:8] hold the prescaler P, bit 5 enables counting, bits [4:3] select the divider, bit 2 enables the interrupt and bit 0 enables the reset. All other bits read 0. Any other address reads 0, and a write to it changes nothing.
- R3: While counting is enabled, the counter drops by one every (P+1)·D clock cycles, where D = 16 << bits[4:3].
- R4: Every write to control restarts both dividing stages from zero. The next tick therefore comes a full (P+1)·D cycles after that write.
- R5: A write to count loads the written value at that clock edge. The write takes priority over a tick that falls on the same edge.
- R6: A tick that finds the counter at 1 or 0 is an expiry. The counter then reloads from the reload register instead of decrementing.
- R7: After an expiry with the interrupt enabled, the interrupt output is high for exactly the one following cycle.
- R8: After an expiry with the reset enabled, the reset output rises on the following cycle and stays high for 128 clock cycles.
- R9: While counting is disabled, the count value does not change unless software writes it.
- R10: The forced-reset sequence works as follows. Software writes control 0, writes count and reload 0x80, then writes control 0x2021. The reset output is then raised exactly 128·33·16 cycles after the final write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_pulse | output | 1 | One-cycle expiry interrupt |
| rst_out | output | 1 | Registered 128-cycle expiry reset pulse |

## Verification
A wrong divider phase or a lost prescaler clear shows up on the next count readback. It is then wrong by one count, at the latest one tick period after the fault. A bad reload or a wrong expiry threshold moves or suppresses the interrupt and the reset. The count read just after the expiry then differs from the reload value. A reset stretcher that holds the pulse too long or too short is seen at the falling edge of the reset output, 128 cycles after the expiry.

// File: rtl/wdog_pkg.sv
// Shared constants, control-register layout and conversion helpers for the
// watchdog timer. Assumes a 32-bit register bus and byte addressing.
package wdog_pkg;

    localparam int PRE_W  = 8;
    localparam int SEL_W  = 2;
    localparam int BASE_LOG2 = 4;          // smallest fixed divider is 2**4

    localparam int OFF_CTRL   = 'h0;
    localparam int OFF_RELOAD = 'h4;
    localparam int OFF_COUNT  = 'h8;

    localparam logic [15:0] CNT_RESET_VAL = 16'h8000;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             run;
        logic [SEL_W-1:0] sel;
        logic             irq_en;
        logic             rst_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET_VAL = '{pre: 8'h80, run: 1'b1, sel: 2'd3,
                                         irq_en: 1'b0, rst_en: 1'b1};

    // Place control fields at their bus bit positions.
    function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
        logic [31:0] w;
        w        = '0;
        w[15:8]  = c.pre;
        w[5]     = c.run;
        w[4:3]   = c.sel;
        w[2]     = c.irq_en;
        w[0]     = c.rst_en;
        return w;
    endfunction

    // Extract control fields from a written bus word.
    function automatic ctrl_t word_to_ctrl(input logic [15:0] w);
        ctrl_t c;
        c.pre    = w[15:8];
        c.run    = w[5];
        c.sel    = w[4:3];
        c.irq_en = w[2];
        c.rst_en = w[0];
        return c;
    endfunction

endpackage

// File: rtl/wdog_tick_gen.sv
// Two-stage clock-enable chain: a programmable prescaler (divide by pre+1)
// followed by a power-of-two divider (2**(BASE_LOG2+sel)). Emits a one-cycle
// tick. Assumes pre and sel only change together with a clear pulse.
module wdog_tick_gen #(
    parameter int PRE_W     = 8,
    parameter int SEL_W     = 2,
    parameter int BASE_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [PRE_W-1:0] pre_val,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = BASE_LOG2 + (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W:0]   div_len;
    logic [DIV_W-1:0] div_last;
    logic             pre_hit;
    logic             div_hit;

    // Terminal value of the fixed divider for the selected ratio.
    always_comb begin
        div_len  = (DIV_W+1)'(1) << (BASE_LOG2 + int'(sel));
        div_last = DIV_W'(div_len - 1'b1);
    end

    // Terminal detection for both stages and the qualified tick.
    always_comb begin
        pre_hit = (pre_cnt == pre_val);
        div_hit = (div_cnt == div_last);
        tick    = run & ~clear & pre_hit & div_hit;
    end

    // Advance the prescaler every cycle and the divider on prescaler wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_hit) begin
            pre_cnt <= '0;
            div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_down_counter.sv
// Watchdog down-counter with software load and automatic reload. A tick at a
// count of 1 or 0 is an expiry and reloads from reload_val. Assumes a software
// load outranks a coincident tick.
module wdog_down_counter #(
    parameter int               CNT_W   = 16,
    parameter logic [CNT_W-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    // Expiry happens on an unpreempted tick at the bottom of the range.
    always_comb expire = tick & ~load & (count <= CNT_W'(1));

    // Count register update: load, reload on expiry, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= RST_VAL;
        else if (load)
            count <= load_val;
        else if (expire)
            count <= reload_val;
        else if (tick)
            count <= count - 1'b1;
    end
endmodule

// File: rtl/wdog_pulse_stretch.sv
// Stretches a one-cycle fire request into a registered pulse LEN cycles long.
// A new fire while active restarts the full length.
module wdog_pulse_stretch #(
    parameter int LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);
    localparam int W = $clog2(LEN + 1);

    logic [W-1:0] remain_q;
    logic [W-1:0] remain_d;

    // Next remaining-cycle count.
    always_comb begin
        if (fire)
            remain_d = W'(LEN);
        else if (remain_q != '0)
            remain_d = remain_q - 1'b1;
        else
            remain_d = '0;
    end

    // Hold the remaining count and a registered copy of its non-zero state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            active   <= 1'b0;
        end else begin
            remain_q <= remain_d;
            active   <= (remain_d != '0);
        end
    end
endmodule

// File: rtl/wdog_timer.sv
// Watchdog timer top: register file, tick chain, counter and output stages.
// Registers decode on the full byte address; reads are combinational.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int CNT_W      = 16,
    parameter int RST_CYCLES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_pulse,
    output logic              rst_out
);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(CNT_RESET_VAL);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_w;
    logic             tick_w;
    logic             expire_w;
    logic             rst_fire;
    logic             hit_ctrl, hit_reload, hit_count;
    logic             wr_ctrl, wr_reload, wr_count;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[31:16];

    // Address decode and write strobes.
    always_comb begin
        hit_ctrl   = (bus_addr == ADDR_W'(OFF_CTRL));
        hit_reload = (bus_addr == ADDR_W'(OFF_RELOAD));
        hit_count  = (bus_addr == ADDR_W'(OFF_COUNT));
        wr_ctrl    = bus_we & hit_ctrl;
        wr_reload  = bus_we & hit_reload;
        wr_count   = bus_we & hit_count;
    end

    // Control and reload registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= CTRL_RESET_VAL;
            reload_q <= CNT_INIT;
        end else begin
            if (wr_ctrl)   ctrl_q   <= word_to_ctrl(bus_wdata[15:0]);
            if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
        end
    end

    wdog_tick_gen #(
        .PRE_W(PRE_W), .SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)
    ) u_tick (
        .clk(clk), .rst_n(rst_n), .clear(wr_ctrl), .run(ctrl_q.run),
        .pre_val(ctrl_q.pre), .sel(ctrl_q.sel), .tick(tick_w)
    );

    wdog_down_counter #(
        .CNT_W(CNT_W), .RST_VAL(CNT_INIT)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(wr_count),
        .load_val(bus_wdata[CNT_W-1:0]), .tick(tick_w),
        .reload_val(reload_q), .count(cnt_w), .expire(expire_w)
    );

    assign rst_fire = expire_w & ctrl_q.rst_en;

    wdog_pulse_stretch #(
        .LEN(RST_CYCLES)
    ) u_rst (
        .clk(clk), .rst_n(rst_n), .fire(rst_fire), .active(rst_out)
    );

    // One-cycle registered interrupt on an enabled expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_pulse <= 1'b0;
        else        irq_pulse <= expire_w & ctrl_q.irq_en;
    end

    // Register readback multiplexer.
    always_comb begin
        if (hit_ctrl)
            bus_rdata = ctrl_to_word(ctrl_q);
        else if (hit_reload)
            bus_rdata = 32'(reload_q);
        else if (hit_count)
            bus_rdata = 32'(cnt_w);
        else
            bus_rdata = '0;
    end
endmodule

// File: rtl/wdog_timer_chk.sv
// Temporal checks for the watchdog timer, bound onto every instance.
module wdog_timer_chk #(
    parameter int ADDR_W     = 4,
    parameter int CNT_W      = 16,
    parameter int RST_CYCLES = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic              irq_pulse,
    input logic              rst_out,
    input logic              run,
    input logic              tick,
    input logic              rst_fire,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  reload
);
    logic kick;
    logic [$clog2(RST_CYCLES+2)-1:0] hi_len;

    assign kick = bus_we && (bus_addr == ADDR_W'(8));

    // Length of the current reset pulse, restarted by each fire request.
    always_ff @(posedge clk) begin
        if (!rst_n)        hi_len <= '0;
        else if (rst_fire) hi_len <= 1;
        else if (rst_out)  hi_len <= hi_len + 1'b1;
        else               hi_len <= '0;
    end

    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !kick && cnt > CNT_W'(1)) |=> cnt == $past(cnt) - CNT_W'(1));

    // R5
    kick_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> cnt == $past(bus_wdata[CNT_W-1:0]));

    // R6
    reload_on_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> cnt == $past(reload));

    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R8
    rst_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |-> hi_len <= ($bits(hi_len))'(RST_CYCLES));

    // R8
    rst_len_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> hi_len == ($bits(hi_len))'(RST_CYCLES + 1));

    // R9
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !kick) |=> $stable(cnt));
endmodule

bind wdog_timer wdog_timer_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)
) u_wdog_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .irq_pulse(irq_pulse), .rst_out(rst_out),
    .run(ctrl_q.run), .tick(tick_w), .rst_fire(rst_fire),
    .cnt(cnt_w), .reload(reload_q)
);

// File: tb/test_wdog_timer.sv
// Bench: behavioural per-cycle reference model plus directed corner checks.
module test_wdog_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq_pulse;
    logic        rst_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    wdog_timer i_wdog_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pulse(irq_pulse), .rst_out(rst_out)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int m_ctrl, m_data, m_cnt, m_el, m_rl;
    bit m_irq;

    function automatic int model_read(input logic [3:0] a);
        case (a)
            4'h0: return m_ctrl;
            4'h4: return m_data;
            4'h8: return m_cnt;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 'h8039; m_data = 'h8000; m_cnt = 'h8000;
            m_el = 0; m_rl = 0; m_irq = 0;
        end else begin
            bit w_c, w_d, w_n, run, tk, ex;
            int period;
            w_c = bus_we && bus_addr == 4'h0;
            w_d = bus_we && bus_addr == 4'h4;
            w_n = bus_we && bus_addr == 4'h8;
            run = m_ctrl[5];
            period = (((m_ctrl >> 8) & 'hFF) + 1) * (16 << ((m_ctrl >> 3) & 3));
            tk = run && (m_el == period - 1) && !w_c;
            ex = tk && !w_n && (m_cnt <= 1);
            m_irq = ex && m_ctrl[2];
            if (ex && m_ctrl[0]) m_rl = 128;
            else if (m_rl > 0)   m_rl--;
            if (w_c || !run || m_el == period - 1) m_el = 0;
            else m_el++;
            if (w_n)      m_cnt = bus_wdata & 'hFFFF;
            else if (ex)  m_cnt = m_data;
            else if (tk)  m_cnt = m_cnt - 1;
            if (w_d) m_data = bus_wdata & 'hFFFF;
            if (w_c) m_ctrl = bus_wdata & 'hFF3D;
        end
    end

    // Compare the outputs with the model in the middle of each high phase.
    always begin
        @(posedge clk);
        #5;
        if (!finished) begin
            chk("R7 irq vs model", int'(irq_pulse), int'(m_irq));
            chk("R8 rst vs model", int'(rst_out), int'(m_rl > 0));
            chk("R2 rdata vs model", int'(bus_rdata), model_read(bus_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, input int exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, int'(bus_rdata), exp);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset values
        rd(4'h0, 'h8039, "R1 ctrl reset");
        rd(4'h4, 'h8000, "R1 reload reset");
        rd(4'h8, 'h8000, "R1 count reset");
        chk("R1 irq low", int'(irq_pulse), 0);
        chk("R1 rst low", int'(rst_out), 0);

        // R2 field masking and unmapped address
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, 'hFF3D, "R2 ctrl mask");
        wr(4'h0, 32'h0);
        wr(4'h4, 32'hABCD_1234);
        rd(4'h4, 'h1234, "R2 reload width");
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, 0, "R2 unmapped reads zero");
        rd(4'h4, 'h1234, "R2 unmapped write ignored reload");
        rd(4'h0, 0, "R2 unmapped write ignored ctrl");
        rd(4'h8, 'h8000, "R2 unmapped write ignored count");

        // R3 / R6 / R7: P=0, div16, interrupt only
        wr(4'h4, 5);
        wr(4'h8, 3);
        wr(4'h0, 'h24);
        idle(15); rd(4'h8, 3, "R3 no tick before period");
        idle(1);  rd(4'h8, 2, "R3 first tick at 16");
        idle(31); rd(4'h8, 1, "R3 count one");
        chk("R7 irq before expiry", int'(irq_pulse), 0);
        idle(1);  chk("R7 irq on expiry", int'(irq_pulse), 1);
        rd(4'h8, 5, "R6 reload on expiry");
        chk("R8 no reset when disabled", int'(rst_out), 0);
        idle(1);  chk("R7 irq single cycle", int'(irq_pulse), 0);

        // R4 control rewrite restarts phase
        wr(4'h0, 'h24);
        idle(15); rd(4'h8, 5, "R4 phase restarted");
        idle(1);  rd(4'h8, 4, "R4 tick a full period later");

        // R3 other divider: P=2, div64 -> 192 cycles
        wr(4'h8, 10);
        wr(4'h0, 'h0230);
        idle(191); rd(4'h8, 10, "R3 div64 before tick");
        idle(1);   rd(4'h8, 9, "R3 div64 tick");

        // R5 kick on the same edge as a tick
        wr(4'h8, 'h100);
        rd(4'h8, 'h100, "R5 immediate load");
        wr(4'h0, 'h0230);
        idle(190);
        wr(4'h8, 'h77);
        rd(4'h8, 'h77, "R5 load beats tick");
        idle(192); rd(4'h8, 'h76, "R5 counting resumes");

        // R9 stop holds the count
        wr(4'h0, 'h0210);
        rd(4'h8, 'h76, "R9 value at stop");
        idle(400);
        rd(4'h8, 'h76, "R9 held while stopped");

        // R6 zero count expires on first tick
        wr(4'h4, 'h42);
        wr(4'h8, 0);
        wr(4'h0, 'h24);
        idle(16);
        chk("R6 zero count expiry irq", int'(irq_pulse), 1);
        rd(4'h8, 'h42, "R6 zero count reload");

        // R8 reset pulse length
        wr(4'h0, 0);
        wr(4'h4, 'h100);
        wr(4'h8, 1);
        wr(4'h0, 'h21);
        idle(15);  chk("R8 reset low before expiry", int'(rst_out), 0);
        idle(1);   chk("R8 reset rises", int'(rst_out), 1);
        chk("R8 no irq when disabled", int'(irq_pulse), 0);
        idle(127); chk("R8 reset held 128", int'(rst_out), 1);
        idle(1);   chk("R8 reset falls", int'(rst_out), 0);

        // R10 forced-reset sequence
        wr(4'h0, 0);
        wr(4'h8, 'h80);
        wr(4'h4, 'h80);
        wr(4'h0, 'h2021);
        idle(67583);
        chk("R10 reset not yet", int'(rst_out), 0);
        rd(4'h8, 1, "R10 count one before expiry");
        idle(1);
        chk("R10 reset asserted", int'(rst_out), 1);
        rd(4'h8, 'h80, "R10 reload after expiry");

        idle(2);
        finish_run();
    end
endmodule